// File: doc/BRIEF.md
# Scan Fake-Word Memory Emulator

This block wraps the output of an embedded synchronous memory so that, during scan-based test pattern generation, the array itself can be treated as cut out of the netlist. In functional mode the real array output reaches the consumer logic unchanged. In scan mode a single register stands in for the whole array. A write stores the incoming data word in it, and a read returns that word with the same number of clock edges of latency as the real array. The logic feeding the memory's data input therefore stays observable, and the logic after its output stays controllable, without a model of the array.

The address and the write/read controls have no stored counterpart in a one-word model. Two observe-only registers sample them on every clock while scan mode is active, so faults on those nets can still be detected. The data bus needs no such register because the emulation word already captures it. The emulation word and both observe registers are brought out as ports so that they can be stitched into a scan chain.

Top module: `fakeword_emu`

## Requirements
- R1: While rstN is low, emuWord, obsAddr and obsCtrl are zero and the scan read result is zero. After reset, with scanMode at 1 and no read issued, dataOut is zero.
- R2: With scanMode at 0, dataOut equals arrayDout in the same cycle, combinationally.
- R3: With scanMode at 1, dataOut does not depend on arrayDout.
- R4: emuWord loads memDin on a clock edge where scanMode and wrEn are both 1. On every other edge it holds, including an edge where wrEn is 1 while scanMode is 0.
- R5: A read (scanMode and rdEn both 1 at an edge) presents the emulation word on dataOut RD_LAT edges after it is sampled, counting the sampling edge as the first. dataOut then holds until the next read result arrives.
- R6: When a read and a write are sampled at the same edge, the read returns the word stored before that write, and the write still takes effect for later reads.
- R7: On each edge with scanMode at 1, obsAddr takes memAddr and obsCtrl takes {wrEn, rdEn} (bit 1 is write, bit 0 is read). With scanMode at 0 both hold.
- R8: Changes on memAddr alone never alter dataOut in scan mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| scanMode | input | 1 | 1 selects array emulation, 0 selects the real array |
| wrEn | input | 1 | Memory write request |
| rdEn | input | 1 | Memory read request |
| memAddr | input | AW | Memory address |
| memDin | input | DW | Memory write data |
| arrayDout | input | DW | Read data from the real array |
| dataOut | output | DW | Data seen by the logic after the memory |
| emuWord | output | DW | Emulation word register |
| obsAddr | output | AW | Observe-only capture of the address |
| obsCtrl | output | 2 | Observe-only capture of {wrEn, rdEn} |

## Verification
The emulation word can receive a write in the same cycle in which a read takes its value into the read pipeline. The bench provokes this by asserting wrEn and rdEn together with a fresh data value. It expects the old word to appear RD_LAT edges later, and the new word on the read that follows. Writes placed directly before reads, and back-to-back reads across a write, check that the scoreboard's ordering matches the latency the design produces.

// File: rtl/fakeword_pkg.sv
package fakeword_pkg;
  localparam int CTRL_W = 2;

  typedef struct packed {
    logic loadWord;
    logic issueRead;
    logic obsCapture;
    logic bypassSel;
  } strobe_t;
endpackage

// File: rtl/fakeword_ctrl.sv
module fakeword_ctrl
  import fakeword_pkg::*;
(
  input  logic    scanMode,
  input  logic    wrEn,
  input  logic    rdEn,
  output strobe_t stb
);
  always_comb begin
    stb            = '0;
    stb.bypassSel  = scanMode;
    stb.obsCapture = scanMode;
    stb.loadWord   = scanMode & wrEn;
    stb.issueRead  = scanMode & rdEn;
  end
endmodule

// File: rtl/fakeword_dpath.sv
module fakeword_dpath
  import fakeword_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 9,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [AW-1:0]     memAddr,
  input  logic [DW-1:0]     memDin,
  input  logic [DW-1:0]     arrayDout,
  output logic [DW-1:0]     dataOut,
  output logic [DW-1:0]     emuWord,
  output logic [AW-1:0]     obsAddr,
  output logic [CTRL_W-1:0] obsCtrl
);
  localparam int STAGES = (RD_LAT > 1) ? RD_LAT - 1 : 1;

  logic [DW-1:0] wordQ;
  logic [DW-1:0] holdQ;
  logic          tailVld;
  logic [DW-1:0] tailData;

  // Single stored word: read samples the old value, so read-before-write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordQ <= '0;
    else if (stb.loadWord) wordQ <= memDin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obsAddr <= '0;
      obsCtrl <= '0;
    end else if (stb.obsCapture) begin
      obsAddr <= memAddr;
      obsCtrl <= {wrEn, rdEn};
    end
  end

  generate
    if (RD_LAT <= 1) begin : gDirect
      assign tailVld  = stb.issueRead;
      assign tailData = wordQ;
    end else begin : gPipe
      logic [DW-1:0] pipeData [STAGES];
      logic [STAGES-1:0] pipeVld;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pipeVld <= '0;
          for (int k = 0; k < STAGES; k++) pipeData[k] <= '0;
        end else begin
          pipeVld[0] <= stb.issueRead;
          if (stb.issueRead) pipeData[0] <= wordQ;
          for (int k = 1; k < STAGES; k++) begin
            pipeVld[k] <= pipeVld[k-1];
            if (pipeVld[k-1]) pipeData[k] <= pipeData[k-1];
          end
        end
      end
      assign tailVld  = pipeVld[STAGES-1];
      assign tailData = pipeData[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        holdQ <= '0;
    else if (tailVld) holdQ <= tailData;
  end

  assign emuWord = wordQ;
  assign dataOut = stb.bypassSel ? holdQ : arrayDout;
endmodule

// File: rtl/fakeword_emu.sv
module fakeword_emu
  import fakeword_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 9,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scanMode,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [AW-1:0]     memAddr,
  input  logic [DW-1:0]     memDin,
  input  logic [DW-1:0]     arrayDout,
  output logic [DW-1:0]     dataOut,
  output logic [DW-1:0]     emuWord,
  output logic [AW-1:0]     obsAddr,
  output logic [CTRL_W-1:0] obsCtrl
);
  strobe_t stb;

  fakeword_ctrl uCtrl (
    .scanMode(scanMode),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .stb     (stb)
  );

  fakeword_dpath #(.DW(DW), .AW(AW), .RD_LAT(RD_LAT)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .memAddr  (memAddr),
    .memDin   (memDin),
    .arrayDout(arrayDout),
    .dataOut  (dataOut),
    .emuWord  (emuWord),
    .obsAddr  (obsAddr),
    .obsCtrl  (obsCtrl)
  );
endmodule

// File: rtl/fakeword_emu_chk.sv
module fakeword_emu_chk #(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rstN,
  input logic          scanMode,
  input logic          wrEn,
  input logic          rdEn,
  input logic [AW-1:0] memAddr,
  input logic [DW-1:0] memDin,
  input logic [DW-1:0] arrayDout,
  input logic [DW-1:0] dataOut,
  input logic [DW-1:0] emuWord,
  input logic [AW-1:0] obsAddr,
  input logic [1:0]    obsCtrl
);
  logic ready;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ready <= 1'b0;
    else       ready <= 1'b1;
  end

  // R2
  func_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !scanMode |-> dataOut == arrayDout);

  // R4
  word_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready && $past(scanMode && wrEn) |-> emuWord == $past(memDin));

  // R4
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready && !$past(scanMode && wrEn) |-> $stable(emuWord));

  // R7
  obs_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready && $past(scanMode) |-> obsAddr == $past(memAddr) && obsCtrl == $past({wrEn, rdEn}));

  // R7
  obs_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready && !$past(scanMode) |-> $stable(obsAddr) && $stable(obsCtrl));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |-> emuWord == '0 && obsAddr == '0 && obsCtrl == '0);
endmodule

bind fakeword_emu fakeword_emu_chk #(.DW(DW), .AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .scanMode(scanMode), .wrEn(wrEn), .rdEn(rdEn),
  .memAddr(memAddr), .memDin(memDin), .arrayDout(arrayDout), .dataOut(dataOut),
  .emuWord(emuWord), .obsAddr(obsAddr), .obsCtrl(obsCtrl)
);

// File: tb/fakeword_emu_test.sv
module fakeword_emu_test;
  localparam int DW  = 16;
  localparam int AW  = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          scanMode = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] memAddr = '0;
  logic [DW-1:0] memDin = '0;
  logic [DW-1:0] arrayDout = '0;
  logic [DW-1:0] dataOut;
  logic [DW-1:0] emuWord;
  logic [AW-1:0] obsAddr;
  logic [1:0]    obsCtrl;

  always #10 clk = ~clk;

  fakeword_emu #(.DW(DW), .AW(AW), .RD_LAT(LAT)) uut (
    .clk(clk), .rstN(rstN), .scanMode(scanMode), .wrEn(wrEn), .rdEn(rdEn),
    .memAddr(memAddr), .memDin(memDin), .arrayDout(arrayDout), .dataOut(dataOut),
    .emuWord(emuWord), .obsAddr(obsAddr), .obsCtrl(obsCtrl)
  );

  typedef struct {
    int          due;
    logic [DW-1:0] val;
    string       tag;
  } item_t;

  item_t         sbQ[$];
  int            cyc = 0;
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;
  logic [DW-1:0] modelWord = '0;
  logic [AW-1:0] expAddr = '0;
  logic [1:0]    expCtrl = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops scoreboard items at the cycle they fall due.
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].due == cyc) begin
      item_t it;
      it = sbQ.pop_front();
      chk(dataOut == it.val, it.tag, dataOut, it.val);
    end
  end

  // Driver: one memory cycle; predicts read data and observe registers.
  task automatic doOp(input bit wr, input bit rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string tag);
    item_t it;
    wrEn = wr; rdEn = rd; memAddr = a; memDin = d;
    if (scanMode && rd) begin
      it.due = cyc + LAT; it.val = modelWord; it.tag = tag;
      sbQ.push_back(it);
    end
    if (scanMode && wr) modelWord = d;
    if (scanMode) begin expAddr = a; expCtrl = {wr, rd}; end
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    chk(obsAddr == expAddr, "R7 addr", DW'(obsAddr), DW'(expAddr));
    chk(obsCtrl == expCtrl, "R7 ctrl", DW'(obsCtrl), DW'(expCtrl));
    chk(emuWord == modelWord, "R4 word", emuWord, modelWord);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] held;
    idle(3);
    // R1: reset state
    chk(emuWord == '0, "R1 word", emuWord, '0);
    chk(obsAddr == '0, "R1 obsAddr", DW'(obsAddr), '0);
    chk(obsCtrl == '0, "R1 obsCtrl", DW'(obsCtrl), '0);
    rstN = 1'b1;
    idle(1);
    scanMode = 1'b1;
    #1;
    chk(dataOut == '0, "R1 dataOut", dataOut, '0);
    scanMode = 1'b0;
    idle(1);
    // R2: functional pass-through
    arrayDout = 16'h1234; #1;
    chk(dataOut == 16'h1234, "R2", dataOut, 16'h1234);
    arrayDout = 16'hBEEF; #1;
    chk(dataOut == 16'hBEEF, "R2", dataOut, 16'hBEEF);
    // R4/R7: functional write ignored, observe regs hold
    doOp(1, 1, 8'h44, 16'h7777, "R4 func");
    chk(emuWord == '0, "R4 func write ignored", emuWord, '0);
    // Scan mode
    scanMode = 1'b1;
    doOp(1, 0, 8'h03, 16'h5555, "R4");
    doOp(0, 1, 8'h03, 16'h0000, "R5 read");
    idle(LAT + 1);
    // R6: read and write at the same edge
    doOp(1, 1, 8'h05, 16'hAAAA, "R6 old word");
    doOp(0, 1, 8'h05, 16'h0000, "R6 new word");
    // back-to-back reads around a write
    doOp(0, 1, 8'h10, 16'h0000, "R5 b2b");
    doOp(1, 0, 8'h11, 16'hC3C3, "R4");
    doOp(0, 1, 8'h12, 16'h0000, "R5 after write");
    doOp(0, 1, 8'hFF, 16'h0000, "R5 repeat");
    idle(LAT + 2);
    // R3: arrayDout has no effect in scan mode
    held = dataOut;
    arrayDout = 16'h0F0F; #1;
    chk(dataOut == held, "R3", dataOut, held);
    arrayDout = 16'hF0F0; #1;
    chk(dataOut == held, "R3", dataOut, held);
    // R8: address changes alone leave dataOut alone
    doOp(0, 0, 8'h81, 16'h0000, "R8");
    doOp(0, 0, 8'h7E, 16'h0000, "R8");
    chk(dataOut == held, "R8", dataOut, held);
    // R5: result holds with no new read
    idle(3);
    chk(dataOut == 16'hC3C3, "R5 hold", dataOut, 16'hC3C3);
    // R2 again after returning to functional mode
    scanMode = 1'b0;
    doOp(1, 0, 8'h22, 16'h9999, "R4 func");
    chk(dataOut == arrayDout, "R2 return", dataOut, arrayDout);
    chk(sbQ.size() == 0, "R5 drain", DW'(sbQ.size()), '0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule